// File: doc/BRIEF.md
# Piecewise-Linear Gamma Correction Unit

This block bends 8-bit video components through a transfer curve that software programs. It does not store all 256 output codes. It keeps one stored output for every eighth input code and fills in the seven codes between two stored points by linear interpolation. There are two curves. The primary curve serves luma, or each of the R, G and B components. The secondary curve is shared by the two colour-difference components (Cb and Cr). The secondary curve has its own slope table, so the software can set a slope for each segment. The primary curve takes its slope from the difference between neighbouring stored points.

Software loads the tables through a write-only register port. Pixels arrive one per cycle with a tag that says which component they carry. Each pixel leaves after a fixed two-register pipeline with its tag attached. The first stage looks up the segment base and slope. The second stage does the multiply, round and clamp. Two enable bits turn each curve on or off. A disabled curve, and the raw tag, pass data through unchanged with the same latency.

Top module: `gpl_gamma_unit`

## Requirements
- R1: Reset clears `out_valid`. After reset, every primary base entry N and every secondary base entry N holds 8*N, and every secondary slope entry holds +8, so that every input code comes out unchanged.
- R2: A pixel sampled with `pix_valid` high at clock edge k appears at edge k+2 with `out_valid` high and its tag unchanged. A cycle with `pix_valid` low gives `out_valid` low two edges later.
- R3: Tag 0 is luma/RGB and uses the primary curve when `gamma_en[0]` is 1. An input 8*N (N = 0..31) gives exactly primary base N.
- R4: For a tag 0 input x with x = 8*N + f and f > 0, the slope is s = base[N+1] - base[N]. The output is base[N] + floor((s*f + 4)/8).
- R5: In the last primary segment (N = 31) there is no next point, so the slope is base[31] - base[30]. The curve is extrapolated up to code 255.
- R6: Every interpolated result is clamped to the range 0..255.
- R7: A write to address 0x40+N stores the data in primary base N and also in secondary base N.
- R8: A write to address 0xC0+N stores the data in secondary base N only. The primary curve is left unchanged.
- R9: A write to address 0xE0+N sets secondary slope N as an 8-bit two's complement value. Tags 1 (Cb) and 2 (Cr) use the secondary curve when `gamma_en[1]` is 1. Their output is ubase[N] + floor((slope*f + 4)/8).
- R10: Some data passes unchanged, with the R2 latency. This covers tag 3 (raw) always, tag 0 when `gamma_en[0]` is 0, and tags 1 and 2 when `gamma_en[1]` is 0. The enable bits are sampled together with the pixel.
- R11: Writes to addresses outside 0x40..0x5F and 0xC0..0xFF change no table entry.
- R12: When a write and a pixel share an edge, the pixel is corrected with the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gamma_en | input | 2 | bit0 enables the primary curve, bit1 enables the secondary curve |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Table write address |
| wr_data | input | 8 | Table write data |
| pix_valid | input | 1 | Input pixel valid |
| pix_tag | input | 2 | 0 luma/RGB, 1 Cb, 2 Cr, 3 raw |
| pix_data | input | 8 | Input component code |
| out_valid | output | 1 | Output pixel valid |
| out_tag | output | 2 | Tag carried with the output |
| out_data | output | 8 | Corrected component code |

## Verification
The hardest cases to reach are the two ends of the last primary segment's extrapolation. From the identity curve at reset, no ordinary gamma-shaped curve ever leaves the 0..255 range. To reach them, the stimulus writes deliberately non-monotone points at entries 30 and 31, so the extrapolated slope drives the result past 0 in one pass and past 255 in another. It also loads extreme signed slopes into the secondary table for the same purpose. The stimulus also issues a table write on the same edge as a pixel that reads the entry being written, to show that the pixel sees the old value. A behavioural model with its own tables is compared on every clock through sweeps and a long pseudo-random run that mixes writes, tags and enables.

// File: rtl/gpl_pkg.sv
package gpl_pkg;
    typedef enum logic [1:0] {
        TAG_MAIN = 2'd0,
        TAG_CB   = 2'd1,
        TAG_CR   = 2'd2,
        TAG_RAW  = 2'd3
    } comp_tag_e;
endpackage

// File: rtl/gpl_table_bank.sv
module gpl_table_bank #(
    parameter int DATA_W   = 8,
    parameter int SEG_BITS = 3,
    parameter int ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] MAIN_ADDR = 8'h40,
    parameter logic [ADDR_W-1:0] UVB_ADDR  = 8'hC0,
    parameter logic [ADDR_W-1:0] UVD_ADDR  = 8'hE0,
    localparam int IDX_W = DATA_W - SEG_BITS,
    localparam int NSEG  = 1 << IDX_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NSEG-1:0][DATA_W-1:0]    main_tab,
    output logic [NSEG-1:0][DATA_W-1:0]    uvb_tab,
    output logic [NSEG-1:0][DATA_W-1:0]    uvd_tab
);
    typedef struct packed {
        logic [NSEG-1:0][DATA_W-1:0] main;
        logic [NSEG-1:0][DATA_W-1:0] uvb;
        logic [NSEG-1:0][DATA_W-1:0] uvd;
    } tab_t;

    function automatic tab_t reset_tab();
        tab_t t;
        for (int n = 0; n < NSEG; n++) begin
            t.main[n] = DATA_W'(n << SEG_BITS);
            t.uvb[n]  = DATA_W'(n << SEG_BITS);
            t.uvd[n]  = DATA_W'(1 << SEG_BITS);
        end
        return t;
    endfunction

    tab_t tab_d, tab_q;
    logic [IDX_W-1:0] idx;
    logic hit_main, hit_uvb, hit_uvd;

    assign idx      = wr_addr[IDX_W-1:0];
    assign hit_main = wr_en && (wr_addr[ADDR_W-1:IDX_W] == MAIN_ADDR[ADDR_W-1:IDX_W]);
    assign hit_uvb  = wr_en && (wr_addr[ADDR_W-1:IDX_W] == UVB_ADDR[ADDR_W-1:IDX_W]);
    assign hit_uvd  = wr_en && (wr_addr[ADDR_W-1:IDX_W] == UVD_ADDR[ADDR_W-1:IDX_W]);

    always_comb begin
        tab_d = tab_q;
        // primary writes mirror into the secondary base (R7)
        if (hit_main) begin
            tab_d.main[idx] = wr_data;
            tab_d.uvb[idx]  = wr_data;
        end
        if (hit_uvb) tab_d.uvb[idx] = wr_data;   // R8
        if (hit_uvd) tab_d.uvd[idx] = wr_data;   // R9
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= reset_tab();
        else        tab_q <= tab_d;
    end

    assign main_tab = tab_q.main;
    assign uvb_tab  = tab_q.uvb;
    assign uvd_tab  = tab_q.uvd;
endmodule

// File: rtl/gpl_fetch.sv
module gpl_fetch #(
    parameter int DATA_W   = 8,
    parameter int SEG_BITS = 3,
    localparam int IDX_W = DATA_W - SEG_BITS,
    localparam int NSEG  = 1 << IDX_W,
    localparam int DW    = DATA_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   gamma_en,
    input  logic                         pix_valid,
    input  logic [1:0]                   pix_tag,
    input  logic [DATA_W-1:0]            pix_data,
    input  logic [NSEG-1:0][DATA_W-1:0]  main_tab,
    input  logic [NSEG-1:0][DATA_W-1:0]  uvb_tab,
    input  logic [NSEG-1:0][DATA_W-1:0]  uvd_tab,
    output logic                         s1_valid,
    output logic [1:0]                   s1_tag,
    output logic [DATA_W-1:0]            s1_base,
    output logic signed [DW-1:0]         s1_delta,
    output logic [SEG_BITS-1:0]          s1_frac
);
    import gpl_pkg::*;

    typedef struct packed {
        logic                  valid;
        logic [1:0]            tag;
        logic [DATA_W-1:0]     base;
        logic signed [DW-1:0]  delta;
        logic [SEG_BITS-1:0]   frac;
    } s1_t;

    s1_t s1_d, s1_q;
    logic [IDX_W-1:0]     seg, nxt;
    logic signed [DW-1:0] main_delta, uv_delta;
    logic                 use_main, use_uv;

    assign seg = pix_data[DATA_W-1:SEG_BITS];
    assign nxt = IDX_W'(seg + 1'b1);

    always_comb begin
        // last segment reuses the slope of the one before it (R5)
        if (seg == IDX_W'(NSEG - 1))
            main_delta = $signed({1'b0, main_tab[NSEG-1]}) - $signed({1'b0, main_tab[NSEG-2]});
        else
            main_delta = $signed({1'b0, main_tab[nxt]}) - $signed({1'b0, main_tab[seg]});
        uv_delta = DW'($signed(uvd_tab[seg]));

        use_main = (pix_tag == TAG_MAIN) && gamma_en[0];
        use_uv   = ((pix_tag == TAG_CB) || (pix_tag == TAG_CR)) && gamma_en[1];

        s1_d.valid = pix_valid;
        s1_d.tag   = pix_tag;
        s1_d.frac  = pix_data[SEG_BITS-1:0];
        if (use_main) begin
            s1_d.base  = main_tab[seg];
            s1_d.delta = main_delta;
        end else if (use_uv) begin
            s1_d.base  = uvb_tab[seg];
            s1_d.delta = uv_delta;
        end else begin
            // bypass: zero slope makes the second stage return the input (R10)
            s1_d.base  = pix_data;
            s1_d.delta = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign s1_valid = s1_q.valid;
    assign s1_tag   = s1_q.tag;
    assign s1_base  = s1_q.base;
    assign s1_delta = s1_q.delta;
    assign s1_frac  = s1_q.frac;
endmodule

// File: rtl/gpl_interp.sv
module gpl_interp #(
    parameter int DATA_W   = 8,
    parameter int SEG_BITS = 3,
    localparam int DW = DATA_W + 1,
    localparam int PW = DW + SEG_BITS + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_valid,
    input  logic [1:0]              s1_tag,
    input  logic [DATA_W-1:0]       s1_base,
    input  logic signed [DW-1:0]    s1_delta,
    input  logic [SEG_BITS-1:0]     s1_frac,
    output logic                    out_valid,
    output logic [1:0]              out_tag,
    output logic [DATA_W-1:0]       out_data
);
    localparam logic signed [PW-1:0] HALF = PW'(1 << (SEG_BITS - 1));
    localparam logic signed [PW-1:0] MAXV = PW'((1 << DATA_W) - 1);

    typedef struct packed {
        logic              valid;
        logic [1:0]        tag;
        logic [DATA_W-1:0] data;
    } o_t;

    o_t o_d, o_q;
    logic signed [PW-1:0] prod, step, sum;

    always_comb begin
        prod = s1_delta * $signed({1'b0, s1_frac});
        step = (prod + HALF) >>> SEG_BITS;                       // R4 rounding
        sum  = $signed({{(PW-DATA_W){1'b0}}, s1_base}) + step;
        o_d.valid = s1_valid;
        o_d.tag   = s1_tag;
        if (sum < 0)         o_d.data = '0;                      // R6
        else if (sum > MAXV) o_d.data = '1;
        else                 o_d.data = sum[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.valid;
    assign out_tag   = o_q.tag;
    assign out_data  = o_q.data;
endmodule

// File: rtl/gpl_gamma_unit.sv
module gpl_gamma_unit #(
    parameter int DATA_W   = 8,
    parameter int SEG_BITS = 3,
    parameter int ADDR_W   = 8,
    localparam int IDX_W = DATA_W - SEG_BITS,
    localparam int NSEG  = 1 << IDX_W,
    localparam int DW    = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        gamma_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pix_valid,
    input  logic [1:0]        pix_tag,
    input  logic [DATA_W-1:0] pix_data,
    output logic              out_valid,
    output logic [1:0]        out_tag,
    output logic [DATA_W-1:0] out_data
);
    logic [NSEG-1:0][DATA_W-1:0] main_tab, uvb_tab, uvd_tab;
    logic                        s1_valid;
    logic [1:0]                  s1_tag;
    logic [DATA_W-1:0]           s1_base;
    logic signed [DW-1:0]        s1_delta;
    logic [SEG_BITS-1:0]         s1_frac;

    gpl_table_bank #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS), .ADDR_W(ADDR_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .main_tab(main_tab), .uvb_tab(uvb_tab), .uvd_tab(uvd_tab)
    );

    gpl_fetch #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_fetch (
        .clk(clk), .rst_n(rst_n), .gamma_en(gamma_en), .pix_valid(pix_valid),
        .pix_tag(pix_tag), .pix_data(pix_data), .main_tab(main_tab),
        .uvb_tab(uvb_tab), .uvd_tab(uvd_tab), .s1_valid(s1_valid), .s1_tag(s1_tag),
        .s1_base(s1_base), .s1_delta(s1_delta), .s1_frac(s1_frac)
    );

    gpl_interp #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_interp (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_tag(s1_tag),
        .s1_base(s1_base), .s1_delta(s1_delta), .s1_frac(s1_frac),
        .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data)
    );
endmodule

// File: rtl/gpl_gamma_chk.sv
module gpl_gamma_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        gamma_en,
    input logic              pix_valid,
    input logic [1:0]        pix_tag,
    input logic [DATA_W-1:0] pix_data,
    input logic              out_valid,
    input logic [1:0]        out_tag,
    input logic [DATA_W-1:0] out_data
);
    logic byp;
    assign byp = (pix_tag == 2'd3) || ((pix_tag == 2'd0) && !gamma_en[0]) ||
                 (((pix_tag == 2'd1) || (pix_tag == 2'd2)) && !gamma_en[1]);

    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> ##1 out_valid);

    a_r2_idle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> ##1 !out_valid);

    a_r2_tag_carry: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> ##1 (out_tag == $past(pix_tag, 2)));

    a_r10_bypass_data: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && byp) |=> ##1 (out_data == $past(pix_data, 2)));
endmodule

bind gpl_gamma_unit gpl_gamma_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gamma_en(gamma_en), .pix_valid(pix_valid),
    .pix_tag(pix_tag), .pix_data(pix_data), .out_valid(out_valid),
    .out_tag(out_tag), .out_data(out_data)
);

// File: tb/tb_gpl_gamma_unit.sv
`timescale 1ns/1ps
module tb_gpl_gamma_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] gamma_en = 2'd3;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic       pix_valid = 1'b0;
    logic [1:0] pix_tag = '0;
    logic [7:0] pix_data = '0;
    logic       out_valid;
    logic [1:0] out_tag;
    logic [7:0] out_data;

    always #2 clk = ~clk;   // 250 MHz

    gpl_gamma_unit dut (
        .clk(clk), .rst_n(rst_n), .gamma_en(gamma_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pix_valid(pix_valid),
        .pix_tag(pix_tag), .pix_data(pix_data), .out_valid(out_valid),
        .out_tag(out_tag), .out_data(out_data)
    );

    int mm[32], mub[32], mud[32];
    int vectors = 0, fails = 0;
    int phase_req = 1;
    bit started = 0, done = 0;
    bit e1v, e2v;
    int e1t, e2t, e1d, e2d, e1r, e2r;

    function automatic int fdiv8(input int t);
        return (t >= 0) ? t / 8 : -((-t + 7) / 8);
    endfunction

    function automatic int gexp(input int t, input int x, input int en, output int req);
        int n, f, b, s, v;
        n = x / 8; f = x % 8;
        if (t == 3 || (t == 0 && en[0] == 0) || (t != 0 && en[1] == 0)) begin
            req = 10; return x;
        end
        if (t == 0) begin
            b = mm[n];
            s = (n == 31) ? mm[31] - mm[30] : mm[n+1] - mm[n];
            req = (n == 31) ? 5 : (f == 0 ? 3 : 4);
        end else begin
            b = mub[n]; s = mud[n]; req = 9;
        end
        v = b + fdiv8(s * f + 4);
        if (v < 0)   begin v = 0;   req = 6; end
        if (v > 255) begin v = 255; req = 6; end
        return v;
    endfunction

    // reference model: result of the pixel on each edge, then the write (R12)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < 32; n++) begin mm[n] = 8*n; mub[n] = 8*n; mud[n] = 8; end
            e1v = 0; e2v = 0; started = 1;
        end else begin
            int r;
            e2v = e1v; e2t = e1t; e2d = e1d; e2r = e1r;
            e1v = pix_valid; e1t = pix_tag;
            e1d = gexp(int'(pix_tag), int'(pix_data), int'(gamma_en), r);
            e1r = (phase_req != 0) ? phase_req : r;
            if (wr_en) begin
                if (wr_addr >= 8'h40 && wr_addr <= 8'h5F) begin
                    mm[wr_addr-8'h40] = wr_data; mub[wr_addr-8'h40] = wr_data;
                end else if (wr_addr >= 8'hC0 && wr_addr <= 8'hDF) begin
                    mub[wr_addr-8'hC0] = wr_data;
                end else if (wr_addr >= 8'hE0) begin
                    mud[wr_addr-8'hE0] = int'($signed(wr_data));
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            vectors++;
            if (out_valid !== e2v) begin
                fails++;
                $display("FAIL R%0d valid: got %0b expected %0b", e2v ? e2r : 2, out_valid, e2v);
            end else if (e2v && (out_data !== e2d[7:0] || out_tag !== e2t[1:0])) begin
                fails++;
                $display("FAIL R%0d data/tag: got %0d/%0d expected %0d/%0d",
                         e2r, out_data, out_tag, e2d, e2t);
            end
        end
    end

    task automatic cyc(input bit we, input logic [7:0] a, input logic [7:0] d,
                       input bit pv, input logic [1:0] t, input logic [7:0] x,
                       input logic [1:0] en);
        wr_en = we; wr_addr = a; wr_data = d;
        pix_valid = pv; pix_tag = t; pix_data = x; gamma_en = en;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, 2'd0, 8'd0, 2'd3);
    endtask

    task automatic sweep(input logic [1:0] t, input logic [1:0] en);
        for (int x = 0; x < 256; x++) cyc(1'b0, 8'd0, 8'd0, 1'b1, t, 8'(x), en);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        @(negedge clk);
        // R1: reset state and identity tables
        for (int i = 0; i < 5; i++) cyc(1'b0, 8'd0, 8'd0, 1'b1, 2'd0, 8'd9, 2'd3);
        rst_n = 1'b1;
        for (int t = 0; t < 4; t++) sweep(2'(t), 2'd3);
        // R7: primary writes mirror into the secondary base
        for (int n = 0; n < 32; n++) wr(8'(8'h40 + n), 8'((n*n*255)/961));
        phase_req = 7; sweep(2'd1, 2'd3);
        // R3 R4 R5 on a convex curve
        phase_req = 0; sweep(2'd0, 2'd3);
        // R5 R6: last segment extrapolates below 0, then above 255
        wr(8'h5E, 8'd250); wr(8'h5F, 8'd10); sweep(2'd0, 2'd3);
        wr(8'h5E, 8'd0);   wr(8'h5F, 8'd200); sweep(2'd0, 2'd3);
        // R8: secondary base only
        for (int n = 0; n < 32; n++) wr(8'(8'hC0 + n), 8'(255 - 8*n));
        phase_req = 8; sweep(2'd0, 2'd3);
        phase_req = 0; sweep(2'd2, 2'd3);
        // R9: signed secondary slopes, with clamping at both ends (R6)
        for (int n = 0; n < 32; n++) wr(8'(8'hE0 + n), (n % 2) ? 8'(n*4) : 8'(-(n*4)));
        wr(8'hC3, 8'd250); wr(8'hE3, 8'd127);
        wr(8'hC4, 8'd3);   wr(8'hE4, 8'h80);
        sweep(2'd1, 2'd3); sweep(2'd2, 2'd3);
        // R11: unmapped writes leave all tables alone
        wr(8'h00, 8'hAA); wr(8'h3F, 8'hAA); wr(8'h60, 8'hAA); wr(8'h80, 8'hAA); wr(8'hBF, 8'hAA);
        phase_req = 11; sweep(2'd0, 2'd3); sweep(2'd1, 2'd3);
        // R10: bypass per enable bit and raw tag
        phase_req = 0;
        for (int e = 0; e < 3; e++) for (int t = 0; t < 4; t++) sweep(2'(t), 2'(e));
        // R12: write and pixel on the same edge
        phase_req = 12;
        cyc(1'b1, 8'h45, 8'h33, 1'b1, 2'd0, 8'd40, 2'd3);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 2'd0, 8'd40, 2'd3);
        cyc(1'b1, 8'hC5, 8'h77, 1'b1, 2'd1, 8'd43, 2'd3);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 2'd1, 8'd43, 2'd3);
        // mixed pseudo-random traffic
        phase_req = 0;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[3] & lfsr[7], {lfsr[15:14], lfsr[5:0]}, lfsr[13:6], lfsr[0] | lfsr[9],
                lfsr[2:1], lfsr[11:4], (lfsr[12:10] == 3'd0) ? lfsr[14:13] : 2'd3);
        end
        for (int i = 0; i < 3; i++) cyc(1'b0, 8'd0, 8'd0, 1'b0, 2'd0, 8'd0, 2'd3);
        finish_run();
    end
endmodule